// File: doc/BRIEF.md
# Boot-Area Command Sequencer

This block watches word writes that land in the boot-RAM window of a paged flash device and turns some of them into actions. A single write of a command word can ask for a warm reset of the device, or fill the first three boot-RAM words with identification bytes. A two-write sequence (an arm word followed by a trigger word) asks an external page-load engine to copy one full page, four 512-byte sectors, into data buffer 0. The page start-address register then moves on to the next page.

The sector number handed to the load engine comes from the block and page start-address registers, which are held outside this block and presented as inputs. The block field can be widened by a density extension bit, with the extension position taken from the device-ID word. The page-load engine, the boot RAM and the start-address registers themselves are outside this block. The sequencer only drives a one-cycle load request with its sector, a write strobe for the page register, a boot-RAM write port and a reset request.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write is decoded only when its word address lies in 0x0000..0x01FF or 0x8000..0x800F. A write to any other address (for example 0x0200 or 0x8010) changes no output and does not arm the sequencer.
- R2: An unarmed, decoded write of 0x00F0 raises rstReq for exactly one cycle, in the cycle after the write. It also clears the armed flag, any pending load and any identification write still in progress.
- R3: A decoded write of 0x00E0 arms the sequencer. The next decoded write always disarms it, and a second value other than 0x0000 (including 0x00F0 or 0x0090) causes no action.
- R4: When the sequencer is armed, a decoded write of 0x0000 with loadBusy low raises loadReq for one cycle, in the cycle after the write, together with loadSector.
- R5: loadSector = ((page[7:2]) + (blockField << 6)) << 2, plus page[1:0]. Here page is the page start register and blockField is that sector field of the block start register.
- R6: blockField = block[11:0], ORed with a density mask when block[15] is 1. The mask is 1 << (6 + devId[6:4]) when devId[3] is 1, and 0 otherwise.
- R7: pageWrEn pulses in the same cycle as loadReq. pageWrData = (page + 4) mod 256, with bits 15:8 zero.
- R8: If loadBusy is high when the trigger is accepted, the load stays pending. loadReq is issued in the cycle after the first clock edge that samples loadBusy low. While the load is pending, decoded writes other than 0x00F0 are ignored.
- R9: An unarmed, decoded write of 0x0090 makes three boot-RAM writes in the three cycles that follow: address 0 gets {8'h00, mfrId[7:0]}, address 1 gets {8'h00, devId[7:0]} and address 2 gets {8'h00, wpStatus[7:0]}.
- R10: Any other unarmed, decoded value is ignored, and a later 0x0000 does not start a load.
- R11: After reset, loadReq, pageWrEn, rstReq and bramWe are low and the sequencer is unarmed.
- R12: An identification write and a load request may occur in the same cycle without disturbing each other. A 0x00F0 write on the clock edge at which a pending load would issue suppresses that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the device word bus |
| wrAddr | input | 16 | Word address of the write |
| wrData | input | 16 | Written word |
| blockReg | input | 16 | Block start-address register |
| pageReg | input | 16 | Page start-address register |
| devId | input | 16 | Device identification word |
| mfrId | input | 16 | Manufacturer identification word |
| wpStatus | input | 16 | Write-protection status word |
| loadBusy | input | 1 | Page-load engine cannot accept a request |
| loadReq | output | 1 | One-cycle full-page load request into buffer 0 |
| loadSector | output | 22 | First sector of the page to load |
| pageWrEn | output | 1 | Write strobe for the page start register |
| pageWrData | output | 16 | Advanced page value |
| rstReq | output | 1 | One-cycle warm reset request |
| bramWe | output | 1 | Boot-RAM write enable |
| bramAddr | output | 9 | Boot-RAM word address |
| bramData | output | 16 | Boot-RAM write data |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an identification write is started and then followed straight away by an arm word and a trigger word. The third identification write then lands in the same cycle as the load request, and both are judged on their own ports in that cycle. In the second, a load is held pending by loadBusy, and loadBusy is dropped on the same edge that samples a 0x00F0 write. The bench expects rstReq with no loadReq in that cycle and no late request afterwards.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  // command words decoded in the boot window
  localparam logic [15:0] CMD_WARM_RST = 16'h00F0;
  localparam logic [15:0] CMD_ARM_LOAD = 16'h00E0;
  localparam logic [15:0] CMD_READ_ID  = 16'h0090;
  localparam logic [15:0] CMD_TRIGGER  = 16'h0000;

  // sector geometry for 2 KiB pages
  localparam int SUB_W      = 2;                       // sectors per page, log2
  localparam int PAGE_IDX_W = 6;                       // pages per block, log2
  localparam int BLK_LO_W   = 12;                      // plain block field
  localparam int DENS_BASE  = 6;                       // density mask base shift
  localparam int DENS_SEL_W = 3;                       // density select width
  localparam int BLKF_W     = DENS_BASE + (1 << DENS_SEL_W);
  localparam int SEC_W      = BLKF_W + PAGE_IDX_W + SUB_W;
  localparam int PAGE_W     = PAGE_IDX_W + SUB_W;      // page register wrap width

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARMED,
    SEQ_PENDING
  } seqState_e;

  typedef struct packed {
    logic issueLoad;
    logic startId;
    logic warmRst;
  } seqStrobes_t;

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LO_WIN_LAST = 'h01FF,
  parameter logic [ADDR_W-1:0] HI_WIN_BASE = 'h8000,
  parameter logic [ADDR_W-1:0] HI_WIN_LAST = 'h800F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadBusy,
  output seqStrobes_t       strb
);

  seqState_e state, stateNxt;
  logic winHit;
  logic isWarm;

  assign winHit = wrEn && ((wrAddr <= LO_WIN_LAST) ||
                           ((wrAddr >= HI_WIN_BASE) && (wrAddr <= HI_WIN_LAST)));
  assign isWarm = (wrData == DATA_W'(CMD_WARM_RST));

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      SEQ_IDLE: begin
        if (winHit) begin
          if (isWarm) begin
            strb.warmRst = 1'b1;
          end else if (wrData == DATA_W'(CMD_ARM_LOAD)) begin
            stateNxt = SEQ_ARMED;
          end else if (wrData == DATA_W'(CMD_READ_ID)) begin
            strb.startId = 1'b1;
          end
        end
      end
      SEQ_ARMED: begin
        if (winHit) begin
          if (wrData == DATA_W'(CMD_TRIGGER)) begin
            if (!loadBusy) begin
              strb.issueLoad = 1'b1;
              stateNxt       = SEQ_IDLE;
            end else begin
              stateNxt = SEQ_PENDING;
            end
          end else begin
            stateNxt = SEQ_IDLE;
          end
        end
      end
      SEQ_PENDING: begin
        if (winHit && isWarm) begin
          strb.warmRst = 1'b1;
          stateNxt     = SEQ_IDLE;
        end else if (!loadBusy) begin
          strb.issueLoad = 1'b1;
          stateNxt       = SEQ_IDLE;
        end
      end
      default: stateNxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNxt;
  end

  // R3: whatever follows the arm word leaves the armed state
  a_r3_next_write_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_ARMED && winHit) |=> (state != SEQ_ARMED));

  // R8: a busy engine keeps the load pending
  a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_PENDING && loadBusy && !(winHit && isWarm)) |=> (state == SEQ_PENDING));

  // R2: a warm reset leaves the sequencer idle
  a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.warmRst |=> (state == SEQ_IDLE));

  // R1: writes above the upper window never arm
  a_r1_outside_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && wrEn && wrAddr > HI_WIN_LAST) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BRAM_AW  = 9,
  parameter int ID_WORDS = 3,
  parameter int DENS_FLAG_BIT = 3,
  parameter int DENS_SEL_LSB  = 4,
  parameter int BLK_EXT_BIT   = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [DATA_W-1:0]  blockReg,
  input  logic [DATA_W-1:0]  pageReg,
  input  logic [DATA_W-1:0]  devId,
  input  logic [DATA_W-1:0]  mfrId,
  input  logic [DATA_W-1:0]  wpStatus,
  output logic               loadReq,
  output logic [SEC_W-1:0]   loadSector,
  output logic               pageWrEn,
  output logic [DATA_W-1:0]  pageWrData,
  output logic               rstReq,
  output logic               bramWe,
  output logic [BRAM_AW-1:0] bramAddr,
  output logic [DATA_W-1:0]  bramData
);

  localparam int SHIFT_W = $clog2(BLKF_W);
  localparam int IDX_W   = $clog2(ID_WORDS);

  // sector computation
  logic [SHIFT_W-1:0]    densShift;
  logic [BLKF_W-1:0]     densMask;
  logic [BLKF_W-1:0]     blkField;
  logic [PAGE_IDX_W-1:0] pageIdx;
  logic [SUB_W-1:0]      subSec;
  logic [SEC_W-1:0]      sectorNxt;
  logic [PAGE_W-1:0]     pageNxt;

  assign densShift = SHIFT_W'(DENS_BASE) + SHIFT_W'(devId[DENS_SEL_LSB +: DENS_SEL_W]);
  assign densMask  = devId[DENS_FLAG_BIT] ? (BLKF_W'(1) << densShift) : '0;
  assign blkField  = BLKF_W'(blockReg[BLK_LO_W-1:0]) | (blockReg[BLK_EXT_BIT] ? densMask : '0);
  assign pageIdx   = pageReg[SUB_W +: PAGE_IDX_W];
  assign subSec    = pageReg[SUB_W-1:0];
  assign sectorNxt = ((SEC_W'(pageIdx) + (SEC_W'(blkField) << PAGE_IDX_W)) << SUB_W)
                     + SEC_W'(subSec);
  assign pageNxt   = pageReg[PAGE_W-1:0] + PAGE_W'(1 << SUB_W);

  // identification word emitter
  logic             idActive;
  logic [IDX_W-1:0] idIdx;
  logic [7:0]       idByte;

  always_comb begin
    case (idIdx)
      IDX_W'(1): idByte = devId[7:0];
      IDX_W'(2): idByte = wpStatus[7:0];
      default:   idByte = mfrId[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReq    <= 1'b0;
      loadSector <= '0;
      pageWrEn   <= 1'b0;
      pageWrData <= '0;
      rstReq     <= 1'b0;
      bramWe     <= 1'b0;
      bramAddr   <= '0;
      bramData   <= '0;
      idActive   <= 1'b0;
      idIdx      <= '0;
    end else begin
      loadReq  <= 1'b0;
      pageWrEn <= 1'b0;
      rstReq   <= 1'b0;
      bramWe   <= 1'b0;
      if (strb.warmRst) begin
        rstReq   <= 1'b1;
        idActive <= 1'b0;
        idIdx    <= '0;
      end else begin
        if (strb.issueLoad) begin
          loadReq    <= 1'b1;
          loadSector <= sectorNxt;
          pageWrEn   <= 1'b1;
          pageWrData <= DATA_W'(pageNxt);
        end
        if (strb.startId) begin
          bramWe   <= 1'b1;
          bramAddr <= '0;
          bramData <= DATA_W'(mfrId[7:0]);
          idIdx    <= IDX_W'(1);
          idActive <= 1'b1;
        end else if (idActive) begin
          bramWe   <= 1'b1;
          bramAddr <= BRAM_AW'(idIdx);
          bramData <= DATA_W'(idByte);
          idIdx    <= idIdx + IDX_W'(1);
          if (idIdx == IDX_W'(ID_WORDS - 1)) idActive <= 1'b0;
        end
      end
    end
  end

  // R12: a warm reset cycle carries neither a load nor an ID write
  a_r12_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (!loadReq && !bramWe));

  // R9: word 0 is followed by word 1 unless restarted or reset
  a_r9_id_order: assert property (@(posedge clk) disable iff (!rstN)
    (bramWe && bramAddr == '0 && !strb.warmRst && !strb.startId)
      |=> (bramWe && bramAddr == BRAM_AW'(1)));

  // R4: the load request is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> !loadReq);

  // R9: emitter addresses stay inside the identification words
  a_r9_id_range: assert property (@(posedge clk) disable iff (!rstN)
    bramWe |-> (bramAddr < BRAM_AW'(ID_WORDS)));

endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int BRAM_AW = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  blockReg,
  input  logic [DATA_W-1:0]  pageReg,
  input  logic [DATA_W-1:0]  devId,
  input  logic [DATA_W-1:0]  mfrId,
  input  logic [DATA_W-1:0]  wpStatus,
  input  logic               loadBusy,
  output logic               loadReq,
  output logic [SEC_W-1:0]   loadSector,
  output logic               pageWrEn,
  output logic [DATA_W-1:0]  pageWrData,
  output logic               rstReq,
  output logic               bramWe,
  output logic [BRAM_AW-1:0] bramAddr,
  output logic [DATA_W-1:0]  bramData
);

  seqStrobes_t strb;

  boot_seq_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .loadBusy (loadBusy),
    .strb     (strb)
  );

  boot_seq_dp #(
    .DATA_W (DATA_W),
    .BRAM_AW(BRAM_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .blockReg   (blockReg),
    .pageReg    (pageReg),
    .devId      (devId),
    .mfrId      (mfrId),
    .wpStatus   (wpStatus),
    .loadReq    (loadReq),
    .loadSector (loadSector),
    .pageWrEn   (pageWrEn),
    .pageWrData (pageWrData),
    .rstReq     (rstReq),
    .bramWe     (bramWe),
    .bramAddr   (bramAddr),
    .bramData   (bramData)
  );

  // R8: no request leaves while the engine was busy at the issuing edge
  a_r8_not_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |-> !$past(loadBusy));

  // R7: page advance travels with every load request
  a_r7_page_with_load: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |-> pageWrEn);

endmodule

// File: tb/tb_boot_cmd_seq.sv
`timescale 1ns/1ps
module tb_boot_cmd_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] blockReg = '0;
  logic [15:0] pageReg = '0;
  logic [15:0] devId = '0;
  logic [15:0] mfrId = '0;
  logic [15:0] wpStatus = '0;
  logic        loadBusy = 1'b0;
  logic        loadReq;
  logic [21:0] loadSector;
  logic        pageWrEn;
  logic [15:0] pageWrData;
  logic        rstReq;
  logic        bramWe;
  logic [8:0]  bramAddr;
  logic [15:0] bramData;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  boot_cmd_seq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .blockReg(blockReg), .pageReg(pageReg), .devId(devId), .mfrId(mfrId),
    .wpStatus(wpStatus), .loadBusy(loadBusy), .loadReq(loadReq),
    .loadSector(loadSector), .pageWrEn(pageWrEn), .pageWrData(pageWrData),
    .rstReq(rstReq), .bramWe(bramWe), .bramAddr(bramAddr), .bramData(bramData)
  );

  typedef struct packed {
    logic [15:0] blk;
    logic [15:0] pg;
    logic [15:0] dev;
    logic [21:0] sec;
    logic [15:0] npg;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{16'h0000, 16'h0000, 16'h0000, 22'h000000, 16'h0004},
    '{16'h0005, 16'h0009, 16'h0000, 22'h000509, 16'h000D},
    '{16'h0FFF, 16'h00FF, 16'h0000, 22'h0FFFFF, 16'h0003},
    '{16'h8003, 16'h00FC, 16'h0028, 22'h0103FC, 16'h0000},
    '{16'h8003, 16'h0010, 16'h0020, 22'h000310, 16'h0014},
    '{16'h8000, 16'h0001, 16'h0078, 22'h200001, 16'h0005},
    '{16'h7ABC, 16'h0102, 16'h0000, 22'h0ABC02, 16'h0006}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, return at the next negedge with outputs settled
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " loadReq"}, 32'(loadReq), 0);
    chk({tag, " rstReq"}, 32'(rstReq), 0);
    chk({tag, " bramWe"}, 32'(bramWe), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 loadReq", 32'(loadReq), 0);
    chk("R11 pageWrEn", 32'(pageWrEn), 0);
    chk("R11 rstReq", 32'(rstReq), 0);
    chk("R11 bramWe", 32'(bramWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    wr(16'h0000, 16'h0000);
    chk("R11 unarmed after reset", 32'(loadReq), 0);

    // R4 R5 R6 R7: vector table of sector and page results
    for (int i = 0; i < 7; i++) begin
      blockReg = VEC[i].blk; pageReg = VEC[i].pg; devId = VEC[i].dev;
      wr(16'h0000, 16'h00E0);
      chk("R4 no early load", 32'(loadReq), 0);
      wr(16'h0100, 16'h0000);
      chk("R4 loadReq", 32'(loadReq), 1);
      chk("R5 R6 loadSector", 32'(loadSector), 32'(VEC[i].sec));
      chk("R7 pageWrEn", 32'(pageWrEn), 1);
      chk("R7 pageWrData", 32'(pageWrData), 32'(VEC[i].npg));
      @(negedge clk);
      chk("R4 single pulse", 32'(loadReq), 0);
    end
    blockReg = 16'h0002; pageReg = 16'h0004; devId = 16'h3428;
    mfrId = 16'h12AB; wpStatus = 16'h0004;

    // R1: window edges
    wr(16'h0200, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R1 0x0200 ignored", 32'(loadReq), 0);
    wr(16'h8010, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R1 0x8010 ignored", 32'(loadReq), 0);
    wr(16'h8010, 16'h00F0);
    chk("R1 out-of-window reset ignored", 32'(rstReq), 0);
    wr(16'h800F, 16'h00E0);
    wr(16'h01FF, 16'h0000);
    chk("R1 window edge load", 32'(loadReq), 1);
    chk("R1 window edge sector", 32'(loadSector), 32'h204);
    @(negedge clk);

    // R2: warm reset pulse
    wr(16'h8000, 16'h00F0);
    chk("R2 rstReq", 32'(rstReq), 1);
    @(negedge clk);
    chk("R2 rstReq one cycle", 32'(rstReq), 0);

    // R3: second write disarms without decoding
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h00F0);
    chk("R3 no reset when armed", 32'(rstReq), 0);
    wr(16'h0000, 16'h0000);
    chk("R3 disarmed", 32'(loadReq), 0);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0090);
    chk("R3 no ID when armed", 32'(bramWe), 0);
    @(negedge clk);
    chk("R3 no ID later", 32'(bramWe), 0);

    // R10: other values ignored
    wr(16'h0000, 16'h1234);
    quiet("R10");
    wr(16'h0000, 16'h0000);
    quiet("R10 after");

    // R9: identification words
    wr(16'h0000, 16'h0090);
    chk("R9 w0 we", 32'(bramWe), 1);
    chk("R9 w0 addr", 32'(bramAddr), 0);
    chk("R9 w0 data", 32'(bramData), 32'h00AB);
    @(negedge clk);
    chk("R9 w1 addr", 32'(bramAddr), 1);
    chk("R9 w1 data", 32'(bramData), 32'h0028);
    @(negedge clk);
    chk("R9 w2 addr", 32'(bramAddr), 2);
    chk("R9 w2 data", 32'(bramData), 32'h0004);
    @(negedge clk);
    chk("R9 done", 32'(bramWe), 0);

    // R8: busy engine defers the request
    loadBusy = 1'b1;
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R8 held while busy", 32'(loadReq), 0);
    wr(16'h0000, 16'h0090);
    chk("R8 ID ignored while pending", 32'(bramWe), 0);
    @(negedge clk);
    chk("R8 still held", 32'(loadReq), 0);
    loadBusy = 1'b0;
    @(negedge clk);
    chk("R8 issued after busy drops", 32'(loadReq), 1);
    chk("R8 sector", 32'(loadSector), 32'h204);
    @(negedge clk);
    chk("R8 single issue", 32'(loadReq), 0);

    // R12: ID write and load in the same cycle
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    chk("R12 overlap loadReq", 32'(loadReq), 1);
    chk("R12 overlap bramWe", 32'(bramWe), 1);
    chk("R12 overlap bramAddr", 32'(bramAddr), 2);
    chk("R12 overlap bramData", 32'(bramData), 32'h0004);
    @(negedge clk);

    // R12: reset on the issuing edge suppresses the pending load
    loadBusy = 1'b1;
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    loadBusy = 1'b0;
    wr(16'h0000, 16'h00F0);
    chk("R12 reset wins rstReq", 32'(rstReq), 1);
    chk("R12 reset wins loadReq", 32'(loadReq), 0);
    @(negedge clk);
    chk("R12 no late load", 32'(loadReq), 0);
    @(negedge clk);
    chk("R2 pending cleared", 32'(loadReq), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule